// File: doc/BRIEF.md
# Double-Edge Byte Link Burst Transmitter

This block takes a frame of twenty captured sample bytes (ten 16-bit channels) and sends it to a DSP receiver over an 8-bit parallel link. The block drives a link clock and places one byte on the bus for every edge of that clock, rising and falling. Every burst is two 128-bit quad-words long, which is 32 bytes or 16 link-clock pulses. The sample bytes come first, and the filler value 0x55 pads the rest of the burst.

The receiver paces the transfer with an acknowledge line. The receiver holds the line low while it takes in a quad-word, and raises it when its buffer is free again. The block starts each quad-word only after it has seen the acknowledge high through a two-flop synchronizer.

A frame is snapshotted when its valid pulse arrives, so the burst always carries a completed conversion. A frame that arrives while a burst is still running is held pending. If yet another frame arrives before the pending one has started, the pending frame is replaced and a sticky overrun flag is raised.

The state machine has three states:
- `ST_IDLE`: waits for a pending frame. When one is present, the transition *take* loads it and goes to `ST_ACK_WAIT`.
- `ST_ACK_WAIT`: waits for the synchronized acknowledge. When it is high, the transition *start* goes to `ST_SHIFT`.
- `ST_SHIFT`: emits one byte per system clock. After the sixteenth byte of a quad-word, the transition *next-quad* returns to `ST_ACK_WAIT` if more quad-words remain. Otherwise the transition *finish* returns to `ST_IDLE`.

Top module: `lnk_burst_tx`

## Requirements
- R1: While reset is asserted, and afterwards until a frame is sent, `link_clk` is 0, `link_data` is 0x00 and `overrun` is 0.
- R2: Each accepted frame produces exactly 32 link-clock edges, forming two quad-words of 16 edges each. Each edge carries one byte.
- R3: Burst byte k, for k from 0 to 19, equals `frame_data[8k+7:8k]`. Channel c occupies `frame_data[16c+15:16c]`, so channels are sent in order from 0 upward, with the low byte before the high byte.
- R4: Burst bytes 20 to 31 are all 0x55.
- R5: `link_clk` is low outside quad-words, and the first edge of a quad-word is rising. `link_data` is 0x00 whenever no quad-word is being sent.
- R6: A quad-word begins only after `link_ack` has been high for the synchronizer delay. No link-clock edge occurs while the block waits for the acknowledge.
- R7: The burst carries the frame value present on the cycle `frame_valid` was sampled. Later changes on `frame_data` do not affect it.
- R8: When `link_ack` is steadily high and the block is idle, the first rising edge of `link_clk` comes on the falling system-clock edge after the second rising edge that follows the edge sampling `frame_valid`. At that point `link_data` already holds byte 0.
- R9: A frame that arrives during a burst is not lost. It is sent immediately after the current burst, in arrival order, and `overrun` stays 0.
- R10: If a frame arrives while another frame is still pending, the newer frame replaces the pending one. `overrun` then becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (twice the link clock rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_data | input | 160 | Ten 16-bit samples, channel 0 in the low bits |
| frame_valid | input | 1 | One-cycle pulse marking a new frame |
| link_ack | input | 1 | Receiver ready (high) / busy (low), asynchronous |
| link_data | output | 8 | Link byte, changes on the rising system-clock edge |
| link_clk | output | 1 | Link clock, toggles on the falling system-clock edge |
| overrun | output | 1 | Sticky flag: a pending frame was replaced |

## Verification
After `frame_valid` is sampled on a rising edge, the frame is taken on the next edge and the start is decided on the edge after that. The first byte is therefore captured half a system clock later. The bench samples `link_clk` 2 ns after that second edge, expecting it low, and again after the falling edge, expecting it high with byte 0 on the bus. The bench also acts as the receiver: it captures a byte on every link-clock edge, lowers the acknowledge at the start of each quad-word, and raises it after a random number of cycles. The bench checks that no quad-word starts before that rise. At the end of each burst, the bench compares the 32 captured bytes with the expected values from its snapshot queue. It checks `overrun` and the idle bus state a few cycles after each burst has ended.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACK_WAIT = 2'd1,
        ST_SHIFT    = 2'd2
    } tx_state_e;
endpackage

// File: rtl/lnk_ack_sync.sv
module lnk_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_async,
    output logic ack_synced
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], ack_async};
    end

    assign ack_synced = sr[STAGES-1];
endmodule

// File: rtl/lnk_frame_hold.sv
module lnk_frame_hold #(
    parameter int FRAME_W = 160
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               frame_valid,
    input  logic               take,
    output logic [FRAME_W-1:0] pend_frame,
    output logic               pend_valid,
    output logic               overrun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_frame <= '0;
            pend_valid <= 1'b0;
            overrun    <= 1'b0;
        end else if (frame_valid) begin
            pend_frame <= frame_in;
            pend_valid <= 1'b1;
            if (pend_valid && !take) overrun <= 1'b1;
        end else if (take) begin
            pend_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/lnk_byte_sel.sv
module lnk_byte_sel #(
    parameter int         DATA_BYTES  = 20,
    parameter int         BURST_BYTES = 32,
    parameter logic [7:0] FILL        = 8'h55,
    localparam int        IDX_W       = $clog2(BURST_BYTES)
) (
    input  logic [DATA_BYTES*8-1:0] frame,
    input  logic [IDX_W-1:0]        idx,
    output logic [7:0]              byte_out
);
    logic [7:0] slots [BURST_BYTES];

    for (genvar g = 0; g < BURST_BYTES; g++) begin : g_slot
        if (g < DATA_BYTES) begin : g_data
            assign slots[g] = frame[g*8 +: 8];
        end else begin : g_fill
            assign slots[g] = FILL;
        end
    end

    assign byte_out = slots[idx];
endmodule

// File: rtl/lnk_burst_tx.sv
module lnk_burst_tx
    import lnk_tx_pkg::*;
#(
    parameter int         NUM_CH          = 10,
    parameter int         SAMPLE_W        = 16,
    parameter int         QUAD_PULSES     = 8,
    parameter int         QUADS           = 2,
    parameter logic [7:0] FILL_BYTE       = 8'h55,
    parameter int         ACK_SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH*SAMPLE_W-1:0]  frame_data,
    input  logic                        frame_valid,
    input  logic                        link_ack,
    output logic [7:0]                  link_data,
    output logic                        link_clk,
    output logic                        overrun
);
    localparam int FRAME_W     = NUM_CH * SAMPLE_W;
    localparam int DATA_BYTES  = FRAME_W / 8;
    localparam int QUAD_BYTES  = 2 * QUAD_PULSES;
    localparam int BURST_BYTES = QUAD_BYTES * QUADS;
    localparam int IDX_W       = $clog2(BURST_BYTES);
    localparam int BCNT_W      = $clog2(QUAD_BYTES);
    localparam int QCNT_W      = (QUADS > 1) ? $clog2(QUADS) : 1;

    tx_state_e          state, state_nx;
    logic               take;
    logic               ack_ok;
    logic [FRAME_W-1:0] pend_frame;
    logic               pend_valid;
    logic [FRAME_W-1:0] active;
    logic [BCNT_W-1:0]  byte_cnt;
    logic [QCNT_W-1:0]  qw_cnt;
    logic [IDX_W-1:0]   byte_idx;
    logic [7:0]         sel_byte;
    logic               quad_done;
    logic               last_quad;

    lnk_ack_sync #(.STAGES(ACK_SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_async  (link_ack),
        .ack_synced (ack_ok)
    );

    lnk_frame_hold #(.FRAME_W(FRAME_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_in    (frame_data),
        .frame_valid (frame_valid),
        .take        (take),
        .pend_frame  (pend_frame),
        .pend_valid  (pend_valid),
        .overrun     (overrun)
    );

    lnk_byte_sel #(
        .DATA_BYTES  (DATA_BYTES),
        .BURST_BYTES (BURST_BYTES),
        .FILL        (FILL_BYTE)
    ) u_sel (
        .frame    (active),
        .idx      (byte_idx),
        .byte_out (sel_byte)
    );

    assign quad_done = (byte_cnt == BCNT_W'(QUAD_BYTES - 1));
    assign last_quad = (qw_cnt == QCNT_W'(QUADS - 1));
    assign byte_idx  = IDX_W'(qw_cnt) * IDX_W'(QUAD_BYTES) + IDX_W'(byte_cnt);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: take, start, next-quad, finish
    always_comb begin
        state_nx = state;
        take     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pend_valid) begin
                    take     = 1'b1;
                    state_nx = ST_ACK_WAIT;
                end
            end
            ST_ACK_WAIT: begin
                if (ack_ok) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (quad_done) state_nx = last_quad ? ST_IDLE : ST_ACK_WAIT;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Burst snapshot and position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active   <= '0;
            byte_cnt <= '0;
            qw_cnt   <= '0;
        end else if (take) begin
            active   <= pend_frame;
            byte_cnt <= '0;
            qw_cnt   <= '0;
        end else if (state == ST_SHIFT) begin
            if (quad_done) begin
                byte_cnt <= '0;
                qw_cnt   <= qw_cnt + QCNT_W'(1);
            end else begin
                byte_cnt <= byte_cnt + BCNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        link_data = (state == ST_SHIFT) ? sel_byte : 8'h00;
    end

    // Link clock edge lands mid-cycle, half a system clock after the data
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)                 link_clk <= 1'b0;
        else if (state == ST_SHIFT) link_clk <= ~link_clk;
    end
endmodule

// File: rtl/lnk_burst_tx_chk.sv
module lnk_burst_tx_chk
    import lnk_tx_pkg::*;
#(
    parameter int SYNC       = 2,
    parameter int QUAD_EDGES = 16
) (
    input logic      clk,
    input logic      rst_n,
    input tx_state_e state,
    input logic      link_clk,
    input logic      link_ack,
    input logic      frame_valid,
    input logic      pend_valid,
    input logic      overrun
);
    logic       clk_prev;
    logic [5:0] edge_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev <= 1'b0;
            edge_cnt <= '0;
        end else begin
            clk_prev <= link_clk;
            if (state != ST_SHIFT)          edge_cnt <= '0;
            else if (link_clk != clk_prev)  edge_cnt <= edge_cnt + 6'd1;
        end
    end

    a_r5_clk_low_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT) |-> !link_clk);

    a_r6_ack_before_quad: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) != ST_SHIFT) |-> $past(link_ack, SYNC + 1));

    a_r2_quad_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT && $past(state) == ST_SHIFT) |-> (edge_cnt == 6'(QUAD_EDGES)));

    a_r9_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> pend_valid);

    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind lnk_burst_tx lnk_burst_tx_chk #(
    .SYNC       (ACK_SYNC_STAGES),
    .QUAD_EDGES (2 * QUAD_PULSES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .link_clk    (link_clk),
    .link_ack    (link_ack),
    .frame_valid (frame_valid),
    .pend_valid  (pend_valid),
    .overrun     (overrun)
);

// File: tb/lnk_burst_tx_bench.sv
module lnk_burst_tx_bench;
    localparam int FW = 160;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] frame_data = '0;
    logic          frame_valid = 1'b0;
    logic          link_ack = 1'b1;
    logic [7:0]    link_data;
    logic          link_clk;
    logic          overrun;

    int n_chk = 0;
    int n_fail = 0;
    int rx_cnt = 0;
    int rx_bursts = 0;
    int rx_gap = 2;
    bit ack_ok = 1'b1;
    logic [7:0]    rx_buf [32];
    logic [FW-1:0] exp_q [$];

    lnk_burst_tx u_lnk_burst_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_data  (frame_data),
        .frame_valid (frame_valid),
        .link_ack    (link_ack),
        .link_data   (link_data),
        .link_clk    (link_clk),
        .overrun     (overrun)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [FW-1:0] f, input int k);
        return (k < 20) ? f[8*k +: 8] : 8'h55;
    endfunction

    function automatic logic [FW-1:0] rand_frame();
        logic [FW-1:0] f;
        for (int i = 0; i < 5; i++) f[32*i +: 32] = $urandom;
        return f;
    endfunction

    task automatic send_frame(input logic [FW-1:0] f, input bit expect_it);
        @(posedge clk); #1;
        frame_data  = f;
        frame_valid = 1'b1;
        if (expect_it) exp_q.push_back(f);
        @(posedge clk); #1;
        frame_valid = 1'b0;
        frame_data  = rand_frame();   // R7: later input changes must not leak
    endtask

    task automatic wait_bursts(input int target);
        wait (rx_bursts >= target);
        repeat (4) @(posedge clk);
        #2;
        chk(rx_cnt % 32 == 0, "R2 edge count", rx_cnt, rx_bursts * 32);
        chk(!link_clk && link_data == 8'h00, "R5 idle bus", {link_clk, link_data}, 0);
    endtask

    // Receiver model: byte per link edge, acknowledge per quad-word
    initial begin
        forever begin
            logic [7:0] b;
            @(posedge link_clk or negedge link_clk);
            b = link_data;
            if (rx_cnt % 16 == 0) begin
                chk(ack_ok, "R6 quad started before ack", 0, 1);
                link_ack = 1'b0;
                ack_ok   = 1'b0;
            end
            rx_buf[rx_cnt % 32] = b;
            rx_cnt++;
            if (rx_cnt % 32 == 0) begin
                logic [FW-1:0] f;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected burst", rx_bursts, 0);
                end else begin
                    f = exp_q.pop_front();
                    for (int k = 0; k < 32; k++)
                        chk(rx_buf[k] == exp_byte(f, k), (k < 20) ? "R3 sample byte" : "R4 filler byte",
                            rx_buf[k], exp_byte(f, k));
                end
                rx_bursts++;
            end
            if (rx_cnt % 16 == 0) begin
                repeat (rx_gap) @(posedge clk);
                #1;
                link_ack = 1'b1;
                ack_ok   = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [FW-1:0] fa;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #2;
        chk(link_clk == 1'b0, "R1 link_clk in reset", link_clk, 0);
        chk(link_data == 8'h00, "R1 link_data in reset", link_data, 0);
        chk(overrun == 1'b0, "R1 overrun in reset", overrun, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #2;
        chk(link_clk == 1'b0 && link_data == 8'h00 && !overrun, "R1 after reset",
            {overrun, link_clk, link_data}, 0);

        // R8: latency with acknowledge steadily high
        fa = rand_frame();
        @(posedge clk); #1;
        frame_data  = fa;
        frame_valid = 1'b1;
        exp_q.push_back(fa);
        @(posedge clk); #1;               // edge sampling frame_valid
        frame_valid = 1'b0;
        frame_data  = ~fa;                // R7
        @(posedge clk);                   // take
        @(posedge clk);                   // start
        #2;
        chk(link_clk == 1'b0, "R8 edge too early", link_clk, 0);
        #5;
        chk(link_clk == 1'b1, "R8 first rising edge", link_clk, 1);
        chk(link_data == fa[7:0], "R8 byte 0 on bus", link_data, fa[7:0]);
        wait_bursts(1);

        // Random frames with random acknowledge gaps
        for (int i = 0; i < 12; i++) begin
            rx_gap = int'($urandom_range(0, 6));
            send_frame(rand_frame(), 1'b1);
            wait_bursts(rx_bursts + 1);
            repeat ($urandom_range(0, 5)) @(posedge clk);
        end

        // R6: long receiver hold-off
        rx_gap = 40;
        send_frame(rand_frame(), 1'b1);
        wait_bursts(rx_bursts + 1);
        rx_gap = 1;

        // R9: frame arrives mid-burst
        begin
            int base;
            base = rx_bursts;
            send_frame(rand_frame(), 1'b1);
            repeat (6) @(posedge clk);
            send_frame(rand_frame(), 1'b1);
            wait_bursts(base + 2);
            chk(overrun == 1'b0, "R9 no overrun for one pending", overrun, 0);
        end

        // R10: two frames queued behind a running burst
        begin
            int base;
            base = rx_bursts;
            send_frame(rand_frame(), 1'b1);
            repeat (3) @(posedge clk);
            send_frame(rand_frame(), 1'b0);  // replaced, never sent
            repeat (3) @(posedge clk);
            send_frame(rand_frame(), 1'b1);
            wait_bursts(base + 2);
            chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
            send_frame(rand_frame(), 1'b1);
            wait_bursts(base + 3);
            chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);
            chk(exp_q.size() == 0, "R10 replaced frame not sent", exp_q.size(), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule